// File: doc/BRIEF.md
# Configurable External Interrupt Detector

This block watches nine external interrupt request pins and turns activity on each of them into a one-bit request towards the interrupt controller. First, every pin is brought into the clock domain through a short synchroniser. An optional per-pin glitch filter can then be applied. Finally, the result is compared against a condition chosen for that pin.

The condition is set by two controls. A two-bit select per pin chooses rising edge, falling edge, high level or low level. A separate per-pin both-edges enable overrides that select and makes the pin report every transition. The filter can be combined with any of these conditions.

Software configures the block through a narrow write port that carries a register select and a data word. The request outputs feed a central controller. That controller handles priority, vectoring and acknowledgement, which are outside this block.

Top module: `ext_irq_detector`

## Requirements
- R1: An unfiltered pin change reaches the request output on the third rising clock edge after the change is applied: two synchroniser stages plus one output register.
- R2: In rising-edge mode (code 00) or falling-edge mode (code 01), each qualifying transition of the evaluated pin value raises the request for exactly one cycle.
- R3: When a pin's both-edges bit is set, every transition of that pin raises a one-cycle request, whatever that pin's condition code holds.
- R4: In high-level mode (code 10) or low-level mode (code 11), the request is asserted on every cycle in which the evaluated level matches. A pulse of W cycles therefore gives W request cycles.
- R5: With its filter enabled, a pin's evaluated value changes only after the synchronised input has held the new value for FILT_LEN (default 4) consecutive clocks. A shorter pulse raises no request in any mode. A pulse of at least FILT_LEN cycles behaves as it would unfiltered.
- R6: After reset, every request output is low, and every pin detects rising edges with no filter and no both-edges detection.
- R7: In the cycle after any configuration write, edge-type requests are suppressed. This prevents a change of filter or mode setting from producing a request that the pin did not cause.
- R8: A write with select 0 loads the condition codes, with pin p in data bits 2p+1:2p. Select 1 loads the both-edges enables and select 2 loads the filter enables, with pin p in data bit p. Select 3 changes nothing.
- R9: Activity on one pin never raises a request on another pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Configuration write strobe |
| wrSel | input | 2 | Register select for the write |
| wrData | input | 2*NUM_PINS | Write data |
| pinIn | input | NUM_PINS | Asynchronous external request pins |
| irqOut | output | NUM_PINS | Per-pin interrupt requests |

## Verification
The bench targets four kinds of error:
- **Filter threshold.** A three-cycle pulse must vanish under the filter while a four-cycle pulse survives. A filter that counts one sample too few or too many fails one of these two cases.
- **Both-edges precedence.** A pin in both-edges mode with a high-level code must give two requests, not a train. A design that lets the condition code win shows up immediately.
- **Spurious request on configuration.** The filter is switched on between a pin's raw and filtered value disagreeing. Without the hold-off, this produces a falling-edge request the pin never made.
- **Latency and isolation.** Exact-cycle latency checks and cross-pin request counts catch an added or missing register stage, and any leakage between pins.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    COND_RISE = 2'b00,
    COND_FALL = 2'b01,
    COND_HIGH = 2'b10,
    COND_LOW  = 2'b11
  } cond_e;

  localparam logic [1:0] SEL_COND = 2'd0;
  localparam logic [1:0] SEL_BOTH = 2'd1;
  localparam logic [1:0] SEL_FILT = 2'd2;

  typedef struct packed {
    logic riseEn;
    logic fallEn;
    logic highEn;
    logic lowEn;
    logic filtEn;
  } pinStrb_t;

endpackage

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS = 9,
  localparam int DW = 2 * NUM_PINS
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [1:0]      wrSel,
  input  logic [DW-1:0]   wrData,
  output pinStrb_t        strbOut [NUM_PINS],
  output logic            holdOff
);

  logic [DW-1:0]       condQ;
  logic [NUM_PINS-1:0] bothQ;
  logic [NUM_PINS-1:0] filtQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      condQ   <= '0;
      bothQ   <= '0;
      filtQ   <= '0;
      holdOff <= 1'b0;
    end else begin
      holdOff <= wrEn;
      if (wrEn) begin
        unique case (wrSel)
          SEL_COND: condQ <= wrData;
          SEL_BOTH: bothQ <= wrData[NUM_PINS-1:0];
          SEL_FILT: filtQ <= wrData[NUM_PINS-1:0];
          default:  ;
        endcase
      end
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_decode
    always_comb begin
      strbOut[p]        = '0;
      strbOut[p].filtEn = filtQ[p];
      if (bothQ[p]) begin
        strbOut[p].riseEn = 1'b1;
        strbOut[p].fallEn = 1'b1;
      end else begin
        unique case (cond_e'(condQ[2*p +: 2]))
          COND_RISE: strbOut[p].riseEn = 1'b1;
          COND_FALL: strbOut[p].fallEn = 1'b1;
          COND_HIGH: strbOut[p].highEn = 1'b1;
          COND_LOW:  strbOut[p].lowEn  = 1'b1;
          default:   ;
        endcase
      end
    end
  end

  // R8
  both_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wrEn) && $past(wrSel) == SEL_BOTH) |-> bothQ == $past(wrData[NUM_PINS-1:0]));

  // R7
  holdoff_follows_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrEn) |-> holdOff);

endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  localparam int CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     pinIn,
  input  pinStrb_t strb,
  input  logic     holdOff,
  output logic     irqQ
);

  logic [SYNC_STAGES-1:0] syncSh;
  logic                   syncQ;
  logic                   filtQ;
  logic [CW-1:0]          cntQ;
  logic                   effVal;
  logic                   prevQ;
  logic                   edgeHit;
  logic                   levelHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncSh <= '0;
    else       syncSh <= {syncSh[SYNC_STAGES-2:0], pinIn};
  end
  assign syncQ = syncSh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtQ <= 1'b0;
      cntQ  <= '0;
    end else if (syncQ == filtQ) begin
      cntQ <= '0;
    end else if (cntQ == CW'(FILT_LEN - 1)) begin
      filtQ <= syncQ;
      cntQ  <= '0;
    end else begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assign effVal = strb.filtEn ? filtQ : syncQ;

  always_comb begin
    edgeHit  = (strb.riseEn &  effVal & ~prevQ) |
               (strb.fallEn & ~effVal &  prevQ);
    levelHit = (strb.highEn &  effVal) | (strb.lowEn & ~effVal);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ <= 1'b0;
      irqQ  <= 1'b0;
    end else begin
      prevQ <= effVal;
      irqQ  <= (edgeHit & ~holdOff) | levelHit;
    end
  end

  logic riseOnly, highOnly, edgeOnly;
  assign riseOnly = strb.riseEn & ~strb.fallEn & ~strb.highEn & ~strb.lowEn;
  assign highOnly = strb.highEn & ~strb.riseEn & ~strb.fallEn & ~strb.lowEn;
  assign edgeOnly = ~strb.highEn & ~strb.lowEn;

  // R2
  edge_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |=> (!irqQ || !$past(riseOnly)));

  // R5
  filter_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(filtQ) |-> filtQ == $past(syncQ));

  // R4
  level_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(highOnly) |-> irqQ == $past(effVal));

  // R7
  holdoff_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(holdOff) && $past(edgeOnly)) |-> !irqQ);

endmodule

// File: rtl/ext_irq_path.sv
module ext_irq_path
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS    = 9,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  pinStrb_t            strbIn [NUM_PINS],
  input  logic                holdOff,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] irqOut
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chan
    ext_irq_chan #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_chan (
      .clk    (clk),
      .rstN   (rstN),
      .pinIn  (pinIn[p]),
      .strb   (strbIn[p]),
      .holdOff(holdOff),
      .irqQ   (irqOut[p])
    );
  end

endmodule

// File: rtl/ext_irq_detector.sv
module ext_irq_detector
  import ext_irq_pkg::*;
#(
  parameter int NUM_PINS    = 9,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  localparam int DW = 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [1:0]          wrSel,
  input  logic [DW-1:0]       wrData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] irqOut
);

  pinStrb_t strb [NUM_PINS];
  logic     holdOff;

  ext_irq_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .wrData (wrData),
    .strbOut(strb),
    .holdOff(holdOff)
  );

  ext_irq_path #(
    .NUM_PINS   (NUM_PINS),
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) u_path (
    .clk    (clk),
    .rstN   (rstN),
    .strbIn (strb),
    .holdOff(holdOff),
    .pinIn  (pinIn),
    .irqOut (irqOut)
  );

endmodule

// File: tb/ext_irq_detector_tb.sv
`timescale 1ns/1ps
module ext_irq_detector_tb;

  localparam int N    = 9;
  localparam int DW   = 2 * N;
  localparam int FILT = 4;
  localparam realtime HALF = 2.0;

  logic          clk = 1'b0;
  logic          rstN;
  logic          wrEn;
  logic [1:0]    wrSel;
  logic [DW-1:0] wrData;
  logic [N-1:0]  pinIn;
  logic [N-1:0]  irqOut;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(HALF) clk = ~clk;

  ext_irq_detector #(.NUM_PINS(N), .FILT_LEN(FILT)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .pinIn(pinIn), .irqOut(irqOut)
  );

  // Vector fields: pin[16:13] cond[12:11] both[10] filt[9] base[8] width[7:0]
  localparam int NV = 14;
  localparam logic [16:0] VEC [NV] = '{
    {4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 8'd3},
    {4'd1, 2'd1, 1'b0, 1'b0, 1'b0, 8'd5},
    {4'd2, 2'd2, 1'b0, 1'b0, 1'b0, 8'd6},
    {4'd3, 2'd3, 1'b0, 1'b0, 1'b1, 8'd4},
    {4'd4, 2'd0, 1'b1, 1'b0, 1'b0, 8'd5},
    {4'd5, 2'd2, 1'b1, 1'b0, 1'b0, 8'd7},
    {4'd6, 2'd0, 1'b0, 1'b1, 1'b0, 8'd3},
    {4'd7, 2'd0, 1'b0, 1'b1, 1'b0, 8'd4},
    {4'd8, 2'd2, 1'b0, 1'b1, 1'b0, 8'd6},
    {4'd0, 2'd3, 1'b0, 1'b1, 1'b1, 8'd2},
    {4'd1, 2'd0, 1'b1, 1'b1, 1'b1, 8'd5},
    {4'd2, 2'd1, 1'b0, 1'b1, 1'b1, 8'd8},
    {4'd3, 2'd0, 1'b0, 1'b0, 1'b1, 8'd3},
    {4'd4, 2'd3, 1'b0, 1'b1, 1'b1, 8'd5}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [DW-1:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic setPin(input int p, input int cond, input bit both, input bit filt);
    logic [DW-1:0] v;
    v = '0; v[2*p +: 2] = 2'(cond);
    cfgWrite(2'd0, v);
    v = '0; v[p] = both;
    cfgWrite(2'd1, v);
    v = '0; v[p] = filt;
    cfgWrite(2'd2, v);
  endtask

  task automatic restoreCfg();
    cfgWrite(2'd0, '0);
    cfgWrite(2'd1, '0);
    cfgWrite(2'd2, '0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Requirement model: R2, R3, R4, R5
  function automatic int expCount(input int cond, input bit both, input bit filt,
                                  input bit base, input int w);
    if (filt && w < FILT) return 0;
    if (both) return 2;
    case (cond)
      0, 1:    return 1;
      2:       return base ? 0 : w;
      default: return base ? w : 0;
    endcase
  endfunction

  // Drive a pulse of width w away from base on pin p, counting requests.
  task automatic pulseCount(input int p, input bit base, input int w,
                            output int hits, output int leak);
    hits = 0; leak = 0;
    for (int k = 0; k < w + 20; k++) begin
      @(negedge clk);
      if (irqOut[p]) hits++;
      for (int q = 0; q < N; q++) if (q != p && irqOut[q]) leak++;
      pinIn[p] = (k < w) ? ~base : base;
    end
  endtask

  initial begin
    #(HALF * 2 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int hits, leak, e;
    rstN = 1'b0; wrEn = 1'b0; wrSel = '0; wrData = '0; pinIn = '0;
    idle(4);
    // R6: outputs low in reset
    check(irqOut == '0, "R6 reset outputs", int'(irqOut), 0);
    rstN = 1'b1;
    idle(3);

    // R1, R6: default rising, exact latency on pin 6
    @(negedge clk); pinIn[6] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(irqOut[6] == 1'b0, "R1 before third edge", int'(irqOut[6]), 0);
    @(negedge clk);
    check(irqOut[6] == 1'b1, "R1 R6 request on third edge", int'(irqOut[6]), 1);
    @(negedge clk);
    check(irqOut[6] == 1'b0, "R2 one cycle wide", int'(irqOut[6]), 0);
    pinIn[6] = 1'b0;
    idle(10);

    // Table walk: R2 R3 R4 R5 R9
    for (int i = 0; i < NV; i++) begin
      int p, c, w; bit b, f, bs;
      p = int'(VEC[i][16:13]); c = int'(VEC[i][12:11]);
      b = VEC[i][10]; f = VEC[i][9]; bs = VEC[i][8]; w = int'(VEC[i][7:0]);
      pinIn[p] = bs;
      idle(12);
      setPin(p, c, b, f);
      idle(3);
      pulseCount(p, bs, w, hits, leak);
      e = expCount(c, b, f, bs, w);
      check(hits == e, $sformatf("R2/R3/R4/R5 vector %0d", i), hits, e);
      check(leak == 0, $sformatf("R9 vector %0d", i), leak, 0);
      restoreCfg();
      pinIn[p] = 1'b0;
      idle(12);
    end

    // R7: filter enabled while raw and filtered values disagree, falling mode
    setPin(3, 1, 1'b0, 1'b0);
    idle(4);
    @(negedge clk); pinIn[3] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    begin
      logic [DW-1:0] v;
      v = '0; v[3] = 1'b1;
      cfgWrite(2'd2, v);
    end
    hits = 0;
    for (int k = 0; k < 20; k++) begin
      if (irqOut[3]) hits++;
      @(negedge clk);
    end
    check(hits == 0, "R7 no request from config write", hits, 0);
    restoreCfg();
    pinIn[3] = 1'b0;
    idle(12);

    // R8: select 3 changes nothing; pin 0 must stay rising, unfiltered
    cfgWrite(2'd3, '1);
    idle(3);
    pulseCount(0, 1'b0, 2, hits, leak);
    check(hits == 1, "R8 select 3 ignored", hits, 1);
    check(leak == 0, "R8 R9 select 3 no leak", leak, 0);

    // R2 R9: all pins rise together, each reports once
    idle(6);
    hits = 0;
    begin
      int perPin [N];
      for (int q = 0; q < N; q++) perPin[q] = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        for (int q = 0; q < N; q++) if (irqOut[q]) perPin[q]++;
        pinIn = (k < 5) ? '1 : '0;
      end
      for (int q = 0; q < N; q++) if (perPin[q] == 1) hits++;
    end
    check(hits == N, "R2 R9 all pins once", hits, N);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule